// File: doc/BRIEF.md
# Power Management Wake Event Controller

This block gathers wake requests from the slow peripheral pins of a system controller and turns them into one power-management event pin for the chipset. The block watches eleven sources by default. Three are active-low lines: a ring indicator, keyboard data and mouse data. Two are pulses from the watchdog and fan-tachometer logic, which sit outside the block. Two are port lines with their own edge rules. The rest are general-purpose pins. Every source passes through a two-flop synchronizer and an edge detector. Each source sets its own sticky status bit, and software clears that bit by writing a one to it.

Each status bit is masked by its own enable bit. If the global enable is set and any masked bit remains, the event is raised. The pad stage then presents the event with a selectable active level and either an open-drain or a push-pull buffer. The block latches status even while the global enable is off, so software can poll for wakes without taking an event.

Register map (3-bit address, 16-bit data). Address 0 is control: bit 0 is the global enable, bit 1 selects active-high output when 1, bit 7 selects push-pull when 1 and open-drain when 0, and bit 15 is the read-only summary flag. Address 1 holds the status bits and clears them on a write of 1. Address 2 holds the per-source enables. Address 3 holds the GPIO invert bits. Address 4 holds the GPIO both-edge bits. Address 5 holds the port-line both-edge bits, with bit 0 for line A and bit 1 for line B. Source bit positions are: 0 ring, 1 keyboard, 2 mouse, 3 watchdog, 4 tachometer, 5 port line A, 6 port line B, and 7 upward for GPIO 0 and up.

Top module: `pmwake_ctrl`

## Requirements
- R1: The event output `pme_evt_o` is high only while the global enable (control bit 0) is set and some status bit has its enable bit set at address 2. When both conditions hold, the event rises within a few cycles.
- R2: A source's status bit latches on that source's active edge, whatever the state of the global enable.
- R3: Writing 1 to a status bit at address 1 clears it, and writing 0 leaves it unchanged. If a new edge and a clearing write hit the same bit in the same cycle, the bit stays set.
- R4: The summary flag (control bit 15) reads 1 while any status bit is set and 0 once all of them are cleared.
- R5: When a GPIO's invert bit (address 3) is 0, its rising edge sets its status bit and its falling edge does not. When the invert bit is 1, only the falling edge sets it.
- R6: When a GPIO's both-edge bit (address 4) is 1, both rising and falling edges set its status bit.
- R7: A port line sets its status bit on a falling edge only while its select bit (address 5) is 0, and on either edge while the select bit is 1. After each clear, every further selected edge sets the bit and raises the event again. `port_req_o` follows the two port-line status bits and drops when they are cleared.
- R8: The ring, keyboard and mouse sources set status on a falling edge only. The watchdog and tachometer pulses set status on a rising edge.
- R9: The pad stage works from the active level set by control bit 1. In push-pull mode (control bit 7 = 1), `pme_oe_o` is 1 and `pme_o` carries the level. In open-drain mode, a low level is driven as `pme_oe_o`=1 with `pme_o`=0, and a high level releases the pad (`pme_oe_o`=0). The pad is never driven high in open-drain mode.
- R10: After reset, all registers read 0. The output is therefore active-low and open-drain, and the pad is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_n_i | input | 1 | Ring indicator, active low, asynchronous |
| kbd_dat_i | input | 1 | Keyboard data line, asynchronous |
| mse_dat_i | input | 1 | Mouse data line, asynchronous |
| wdt_pulse_i | input | 1 | Watchdog expiry pulse |
| tach_pulse_i | input | 1 | Fan tachometer event pulse |
| port_ln_i | input | 2 | Port lines A (bit 0) and B (bit 1) |
| gpio_i | input | NGPIO | General-purpose wake pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| pme_o | output | 1 | Event pad output value |
| pme_oe_o | output | 1 | Event pad output enable |
| pme_evt_o | output | 1 | Event asserted, logical view |
| port_req_o | output | 2 | Port-line requests, follow their status bits |

## Verification
Several properties are checked on every cycle. A status bit never drops unless a clearing write preceded it, and never rises unless an edge was detected. The event never rises without the global enable or without an enabled pending bit. A cleared port-line request falls unless a new edge arrived. An open-drain pad never drives high, and a push-pull pad always drives. Some behaviour is only shown by the bench's scenarios. These are the edge rules of each source kind, the invert and both-edge modes, the event rising again after each clear, the edge winning over a clear in the same cycle, and the exact pad values for each polarity and buffer combination.

// File: rtl/pmwake_pkg.sv
package pmwake_pkg;
    localparam int REG_W   = 16;
    localparam int N_FIXED = 7;

    localparam int SRC_RING = 0;
    localparam int SRC_KBD  = 1;
    localparam int SRC_MSE  = 2;
    localparam int SRC_WDT  = 3;
    localparam int SRC_TACH = 4;
    localparam int SRC_PLA  = 5;
    localparam int SRC_PLB  = 6;

    localparam int CTL_GEN = 0;
    localparam int CTL_POL = 1;
    localparam int CTL_PP  = 7;
    localparam int CTL_SUM = 15;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_STS   = 3'd1,
        A_EN    = 3'd2,
        A_GINV  = 3'd3,
        A_GBOTH = 3'd4,
        A_PBOTH = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic gen_en;
        logic pol_hi;
        logic push_pull;
    } ctrl_t;
endpackage

// File: rtl/pmwake_edge.sv
module pmwake_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise_en,
    input  logic fall_en,
    output logic hit
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_q, sync_d;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign hit = (rise_en &  sync_q.s2 & ~sync_q.s3)
               | (fall_en & ~sync_q.s2 &  sync_q.s3);
endmodule

// File: rtl/pmwake_pad.sv
module pmwake_pad (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic pol_hi,
    input  logic push_pull,
    output logic pad_o,
    output logic pad_oe
);
    logic lvl;

    always_comb begin
        lvl = evt ? pol_hi : ~pol_hi;
        if (push_pull) begin
            pad_oe = 1'b1;
            pad_o  = lvl;
        end else begin
            pad_oe = ~lvl;
            pad_o  = 1'b0;
        end
    end

    // R9: open-drain never drives high
    assert_od_no_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !push_pull |-> !(pad_oe && pad_o));

    // R9: push-pull always drives
    assert_pp_drives_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> pad_oe);
endmodule

// File: rtl/pmwake_ctrl.sv
module pmwake_ctrl
    import pmwake_pkg::*;
#(
    parameter int NGPIO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_n_i,
    input  logic             kbd_dat_i,
    input  logic             mse_dat_i,
    input  logic             wdt_pulse_i,
    input  logic             tach_pulse_i,
    input  logic [1:0]       port_ln_i,
    input  logic [NGPIO-1:0] gpio_i,
    input  logic             reg_wr_i,
    input  logic [2:0]       reg_addr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             pme_o,
    output logic             pme_oe_o,
    output logic             pme_evt_o,
    output logic [1:0]       port_req_o
);
    localparam int NSRC = N_FIXED + NGPIO;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [NSRC-1:0]  sts;
        logic [NSRC-1:0]  en;
        logic [NGPIO-1:0] ginv;
        logic [NGPIO-1:0] gboth;
        logic [1:0]       pboth;
        logic             evt;
    } state_t;

    state_t          st_q, st_d;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] rise_en;
    logic [NSRC-1:0] fall_en;
    logic [NSRC-1:0] hit;
    logic [NSRC-1:0] clr;
    logic            unused_wdata;

    assign unused_wdata = ^reg_wdata_i;
    assign raw = {gpio_i, port_ln_i, tach_pulse_i, wdt_pulse_i,
                  mse_dat_i, kbd_dat_i, ring_n_i};

    // per-source edge rules
    always_comb begin
        rise_en = '0;
        fall_en = '0;
        fall_en[SRC_RING] = 1'b1;
        fall_en[SRC_KBD]  = 1'b1;
        fall_en[SRC_MSE]  = 1'b1;
        rise_en[SRC_WDT]  = 1'b1;
        rise_en[SRC_TACH] = 1'b1;
        for (int k = 0; k < 2; k++) begin
            fall_en[SRC_PLA+k] = 1'b1;
            rise_en[SRC_PLA+k] = st_q.pboth[k];
        end
        for (int g = 0; g < NGPIO; g++) begin
            rise_en[N_FIXED+g] = st_q.gboth[g] | ~st_q.ginv[g];
            fall_en[N_FIXED+g] = st_q.gboth[g] |  st_q.ginv[g];
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        pmwake_edge u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (raw[i]),
            .rise_en (rise_en[i]),
            .fall_en (fall_en[i]),
            .hit     (hit[i])
        );
    end

    // next state
    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (reg_wr_i) begin
            case (reg_addr_e'(reg_addr_i))
                A_CTRL: begin
                    st_d.ctrl.gen_en    = reg_wdata_i[CTL_GEN];
                    st_d.ctrl.pol_hi    = reg_wdata_i[CTL_POL];
                    st_d.ctrl.push_pull = reg_wdata_i[CTL_PP];
                end
                A_STS:   clr        = reg_wdata_i[NSRC-1:0];
                A_EN:    st_d.en    = reg_wdata_i[NSRC-1:0];
                A_GINV:  st_d.ginv  = reg_wdata_i[NGPIO-1:0];
                A_GBOTH: st_d.gboth = reg_wdata_i[NGPIO-1:0];
                A_PBOTH: st_d.pboth = reg_wdata_i[1:0];
                default: ;
            endcase
        end
        st_d.sts = (st_q.sts & ~clr) | hit;
        st_d.evt = st_q.ctrl.gen_en & (|(st_q.sts & st_q.en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_e'(reg_addr_i))
            A_CTRL: begin
                reg_rdata_o[CTL_GEN] = st_q.ctrl.gen_en;
                reg_rdata_o[CTL_POL] = st_q.ctrl.pol_hi;
                reg_rdata_o[CTL_PP]  = st_q.ctrl.push_pull;
                reg_rdata_o[CTL_SUM] = |st_q.sts;
            end
            A_STS:   reg_rdata_o[NSRC-1:0]  = st_q.sts;
            A_EN:    reg_rdata_o[NSRC-1:0]  = st_q.en;
            A_GINV:  reg_rdata_o[NGPIO-1:0] = st_q.ginv;
            A_GBOTH: reg_rdata_o[NGPIO-1:0] = st_q.gboth;
            A_PBOTH: reg_rdata_o[1:0]       = st_q.pboth;
            default: ;
        endcase
    end

    pmwake_pad u_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (st_q.evt),
        .pol_hi    (st_q.ctrl.pol_hi),
        .push_pull (st_q.ctrl.push_pull),
        .pad_o     (pme_o),
        .pad_oe    (pme_oe_o)
    );

    assign pme_evt_o  = st_q.evt;
    assign port_req_o = st_q.sts[SRC_PLB:SRC_PLA];

    // R3: a status bit only falls after a clearing write
    assert_sts_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        &(~$past(st_q.sts) | $past(clr) | st_q.sts));

    // R2: a status bit only rises after a detected edge
    assert_sts_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        &(~st_q.sts | $past(st_q.sts) | $past(hit)));

    // R1: no event without the global enable
    assert_evt_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st_q.ctrl.gen_en) |-> !pme_evt_o);

    // R1: no event without an enabled pending bit
    assert_evt_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pme_evt_o |-> $past(|(st_q.sts & st_q.en)));

    // R7: a cleared port-line request drops unless a new edge came
    assert_portreq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr[SRC_PLA]) && !$past(hit[SRC_PLA])) |-> !port_req_o[0]);
endmodule

// File: tb/pmwake_ctrl_tb.sv
`timescale 1ns/1ps
module pmwake_ctrl_tb_top;
    localparam int NGPIO = 4;
    localparam int K_RD  = 0;
    localparam int K_PAD = 1;
    localparam int K_EVT = 2;
    localparam int K_REQ = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ring_n = 1'b1, kbd = 1'b1, mse = 1'b1;
    logic             wdt = 1'b0, tach = 1'b0;
    logic [1:0]       port = 2'b11;
    logic [NGPIO-1:0] gpio = '0;
    logic             wr = 1'b0;
    logic [2:0]       addr = 3'd0;
    logic [15:0]      wdata = '0;
    logic [15:0]      rdata;
    logic             pme, pme_oe, evt;
    logic [1:0]       preq;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    pmwake_ctrl #(.NGPIO(NGPIO)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .ring_n_i (ring_n), .kbd_dat_i (kbd), .mse_dat_i (mse),
        .wdt_pulse_i (wdt), .tach_pulse_i (tach),
        .port_ln_i (port), .gpio_i (gpio),
        .reg_wr_i (wr), .reg_addr_i (addr), .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pme_o (pme), .pme_oe_o (pme_oe), .pme_evt_o (evt),
        .port_req_o (preq)
    );

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
                K_RD:    act = rdata;
                K_PAD:   act = {14'b0, pme_oe, pme};
                K_EVT:   act = {15'b0, evt};
                default: act = {14'b0, preq};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h",
                         it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_v(int kind, logic [2:0] a, logic [15:0] e, string tag);
        @(posedge clk); #1;
        addr = a;
        q.push_back('{kind, e, tag});
        @(negedge clk); #1;
    endtask

    task automatic wr_reg(logic [2:0] a, logic [15:0] d);
        @(posedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic pulse_wdt();
        @(posedge clk); #1; wdt = 1'b1;
        @(posedge clk); #1; wdt = 1'b0;
    endtask

    task automatic pulse_tach();
        @(posedge clk); #1; tach = 1'b1;
        @(posedge clk); #1; tach = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();

        // R10 reset state
        expect_v(K_RD,  3'd0, 16'h0000, "R10 ctrl");
        expect_v(K_RD,  3'd1, 16'h0000, "R10 sts");
        expect_v(K_RD,  3'd2, 16'h0000, "R10 en");
        expect_v(K_PAD, 3'd0, 16'h0000, "R10 pad released");

        // R2 latch while global enable off
        kbd = 1'b0; settle();
        expect_v(K_RD,  3'd1, 16'h0002, "R2 kbd status");
        expect_v(K_EVT, 3'd1, 16'h0000, "R1 no evt, gen off");

        // R1 gating
        wr_reg(3'd2, 16'h0002); settle();
        expect_v(K_EVT, 3'd0, 16'h0000, "R1 enable only");
        wr_reg(3'd0, 16'h0001); settle();
        expect_v(K_EVT, 3'd0, 16'h0001, "R1 evt raised");
        expect_v(K_PAD, 3'd0, 16'h0002, "R9 od active-low drive");
        expect_v(K_RD,  3'd0, 16'h8001, "R4 summary set");

        // R3 write-one-to-clear
        wr_reg(3'd1, 16'h0000); settle();
        expect_v(K_RD,  3'd1, 16'h0002, "R3 zero write ignored");
        wr_reg(3'd1, 16'h0002); settle();
        expect_v(K_RD,  3'd1, 16'h0000, "R3 cleared");
        expect_v(K_EVT, 3'd0, 16'h0000, "R1 evt dropped");
        expect_v(K_RD,  3'd0, 16'h0001, "R4 summary clear");
        expect_v(K_PAD, 3'd0, 16'h0000, "R9 od released");

        // R8 source edge kinds
        kbd = 1'b1; settle();
        expect_v(K_RD, 3'd1, 16'h0000, "R8 kbd rise ignored");
        ring_n = 1'b0;
        pulse_wdt();
        pulse_tach();
        settle();
        expect_v(K_RD, 3'd1, 16'h0019, "R8 ring wdt tach");
        ring_n = 1'b1;
        wr_reg(3'd1, 16'hFFFF); settle();
        expect_v(K_RD, 3'd1, 16'h0000, "R8 ring rise ignored");

        // R5 GPIO single edge
        gpio[0] = 1'b1; settle();
        expect_v(K_RD, 3'd1, 16'h0080, "R5 gpio0 rise");
        wr_reg(3'd1, 16'h0080);
        gpio[0] = 1'b0; settle();
        expect_v(K_RD, 3'd1, 16'h0000, "R5 gpio0 fall ignored");
        wr_reg(3'd3, 16'h0002);
        gpio[1] = 1'b1; settle();
        expect_v(K_RD, 3'd1, 16'h0000, "R5 gpio1 inv rise ignored");
        gpio[1] = 1'b0; settle();
        expect_v(K_RD, 3'd1, 16'h0100, "R5 gpio1 inv fall");
        wr_reg(3'd1, 16'hFFFF);

        // R6 GPIO both edges
        wr_reg(3'd4, 16'h0004);
        gpio[2] = 1'b1; settle();
        expect_v(K_RD, 3'd1, 16'h0200, "R6 gpio2 rise");
        wr_reg(3'd1, 16'h0200); settle();
        gpio[2] = 1'b0; settle();
        expect_v(K_RD, 3'd1, 16'h0200, "R6 gpio2 fall");
        wr_reg(3'd1, 16'hFFFF);

        // R7 port lines
        wr_reg(3'd0, 16'h0000);
        port[0] = 1'b0; settle();
        expect_v(K_RD,  3'd1, 16'h0020, "R7 port A fall");
        expect_v(K_REQ, 3'd1, 16'h0001, "R7 request up");
        wr_reg(3'd1, 16'h0020); settle();
        expect_v(K_REQ, 3'd1, 16'h0000, "R7 request drops");
        port[0] = 1'b1; settle();
        expect_v(K_RD,  3'd1, 16'h0000, "R7 rise ignored by default");
        port[1] = 1'b0; settle();
        expect_v(K_REQ, 3'd1, 16'h0002, "R7 port B fall");
        wr_reg(3'd1, 16'h0040);
        port[1] = 1'b1; settle();
        expect_v(K_RD,  3'd1, 16'h0000, "R7 port B rise ignored");
        wr_reg(3'd5, 16'h0001);
        wr_reg(3'd2, 16'h0020);
        wr_reg(3'd0, 16'h0001); settle();
        expect_v(K_EVT, 3'd1, 16'h0000, "R7 no event yet");
        port[0] = 1'b0; settle();
        expect_v(K_EVT, 3'd1, 16'h0001, "R7 event on fall");
        wr_reg(3'd1, 16'h0020); settle();
        expect_v(K_EVT, 3'd1, 16'h0000, "R7 event cleared");
        port[0] = 1'b1; settle();
        expect_v(K_EVT, 3'd1, 16'h0001, "R7 event re-raised on rise");
        expect_v(K_RD,  3'd1, 16'h0020, "R7 both-edge rise");
        wr_reg(3'd1, 16'hFFFF); settle();

        // R3 edge and clear in the same cycle
        wr_reg(3'd2, 16'h0200);
        @(posedge clk); #1; gpio[2] = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1; wr = 1'b1; addr = 3'd1; wdata = 16'h0200;
        @(posedge clk); #1; wr = 1'b0;
        settle();
        expect_v(K_RD,  3'd1, 16'h0200, "R3 edge wins over clear");
        expect_v(K_EVT, 3'd1, 16'h0001, "R1 evt from gpio2");

        // R9 pad modes
        wr_reg(3'd0, 16'h0083); settle();
        expect_v(K_PAD, 3'd0, 16'h0003, "R9 pp active-high asserted");
        wr_reg(3'd0, 16'h0081); settle();
        expect_v(K_PAD, 3'd0, 16'h0002, "R9 pp active-low asserted");
        wr_reg(3'd0, 16'h0080); settle();
        expect_v(K_PAD, 3'd0, 16'h0003, "R9 pp active-low idle");
        wr_reg(3'd0, 16'h0002); settle();
        expect_v(K_PAD, 3'd0, 16'h0002, "R9 od active-high idle");
        wr_reg(3'd0, 16'h0003); settle();
        expect_v(K_PAD, 3'd0, 16'h0000, "R9 od active-high released");

        done = 1'b1;
        @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule